// File: doc/BRIEF.md
# Fault-Secure Systematic Encoder with Re-Encode on Detection

This block turns a 7-bit data word into a 15-bit systematic codeword of a (15,7,5) cyclic geometry code and hands it to a storage array. The data word appears unchanged in the low codeword bits. Each of the eight parity bits is formed by its own XOR cone and its own register, and no gate is shared between cones. A single internal upset can therefore disturb at most one codeword bit.

Each encoded word is put in front of an external detector for one cycle. If the detector reports a non-codeword, the block encodes the same data again and presents it again. A word is strobed out for writing only after a check comes back clean. If the number of repeats reaches a parameterised cap, the block raises an unrecoverable-error pulse, drops the word and becomes ready again. A test-only injection input can flip chosen parity bits on the first encode attempt of a word, so that the retry path can be exercised.

Top module: `fsec_encoder`

## Requirements
- R1: Codeword bits 6..0 equal data bits m6..m0 of the accepted word, bit i carrying mi.
- R2: Codeword bits 7..14 carry parity p0..p7, with p0=m0^m4^m6, p1=m0^m1^m4^m5^m6, p2=m0^m1^m2^m4^m5, p3=m1^m2^m3^m5^m6, p4=m0^m2^m3, p5=m1^m3^m4, p6=m2^m4^m5 and p7=m3^m5^m6. The word with only m1 set encodes to 15'h1702.
- R3: After reset, `in_ready` is 1 and `chk_req`, `wr_en` and `unrec_err` are 0.
- R4: A word is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until the word has been written or dropped. Input changes while the block is busy have no effect on the word being handled.
- R5: `chk_req` is 1 in the second cycle after the accepting edge. If `det_err` is 0 in that cycle, `wr_en` is 1 for exactly the next cycle, with `cw_out` unchanged.
- R6: When `det_err` is 1 in a `chk_req` cycle, no write follows. The word is encoded again and `chk_req` returns two cycles later.
- R7: When MAX_RETRY+1 checks of the same word have all failed (default MAX_RETRY=3), `unrec_err` pulses for one cycle instead of `wr_en`. A word whose check passes after at most MAX_RETRY failures is written.
- R8: When `inj_en` is 1 at the accepting edge, `inj_mask` is XORed onto parity bits p0..p7 of the first attempt only. Data bits are unaffected, and the repeat attempt is clean.
- R9: Each injected mask bit pj changes exactly codeword bit 7+j and no other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Block idle and able to take a word |
| in_data | input | 7 | Data word m6..m0 |
| inj_en | input | 1 | Arm parity fault injection for this word |
| inj_mask | input | 8 | Parity bits p7..p0 to flip on the first attempt |
| cw_out | output | 15 | Current codeword, parity p7..p0 over data m6..m0 |
| chk_req | output | 1 | Codeword is presented to the detector this cycle |
| det_err | input | 1 | Detector verdict, sampled in `chk_req` cycles |
| wr_en | output | 1 | Write strobe for `cw_out` |
| unrec_err | output | 1 | Word dropped after the retry cap |

## Verification
The bench sweeps all 128 data words against its own XOR equations, so a wrong tap in any parity cone would produce a wrong written word. It injects each single parity bit in turn and checks that exactly one codeword bit moves. Sharing logic between cones would move more than one bit, and a mask that persisted would cause endless retries. Forced detector failures probe the cap from both sides: MAX_RETRY failures must still end in a write, and one more must end in the unrecoverable pulse. An off-by-one in the retry counter would either drop a recoverable word or write an unchecked one. While the block is busy, the bench keeps offering a different word, so a handshake that accepted early would corrupt the stored data.

// File: rtl/fsec_pkg.sv
`timescale 1ns/1ps
package fsec_pkg;
   localparam int CODE_K = 7;
   localparam int CODE_R = 8;
   localparam int CODE_N = CODE_K + CODE_R;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ENC  = 3'd1,
      ST_CHK  = 3'd2,
      ST_WR   = 3'd3,
      ST_DROP = 3'd4
   } enc_state_t;

   // Data taps of parity bit j, bit i of the result selects data bit mi
   function automatic logic [CODE_K-1:0] parity_taps(input int j);
      logic [CODE_K-1:0] t;
      case (j)
         0: t = 7'b1010001;
         1: t = 7'b1110011;
         2: t = 7'b0110111;
         3: t = 7'b1101110;
         4: t = 7'b0001101;
         5: t = 7'b0011010;
         6: t = 7'b0110100;
         default: t = 7'b1101000;
      endcase
      return t;
   endfunction
endpackage

// File: rtl/fsec_par_cone.sv
`timescale 1ns/1ps
module fsec_par_cone #(
   parameter int              W   = 7,
   parameter logic [W-1:0]    TAP = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         flip,
   output logic         q
);
   logic sum;

   always_comb sum = ^(din & TAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= 1'b0;
      else if (load)
         q <= sum ^ flip;
   end
endmodule

// File: rtl/fsec_retry_fsm.sv
`timescale 1ns/1ps
module fsec_retry_fsm
   import fsec_pkg::*;
#(
   parameter int MAX_RETRY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic det_err,
   output logic in_ready,
   output logic accept,
   output logic load_cw,
   output logic first_try,
   output logic chk_req,
   output logic wr_en,
   output logic unrec_err
);
   localparam int CNT_W = $clog2(MAX_RETRY + 1) + 1;

   enc_state_t        state_q, state_d;
   logic [CNT_W-1:0]  retry_q;

   always_comb begin
      in_ready  = (state_q == ST_IDLE);
      accept    = in_ready && in_valid;
      load_cw   = (state_q == ST_ENC);
      chk_req   = (state_q == ST_CHK);
      wr_en     = (state_q == ST_WR);
      unrec_err = (state_q == ST_DROP);
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (in_valid) state_d = ST_ENC;
         ST_ENC:  state_d = ST_CHK;
         ST_CHK: begin
            if (!det_err)
               state_d = ST_WR;
            else if (retry_q == CNT_W'(MAX_RETRY))
               state_d = ST_DROP;
            else
               state_d = ST_ENC;
         end
         ST_WR:   state_d = ST_IDLE;
         ST_DROP: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         retry_q   <= '0;
         first_try <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            retry_q   <= '0;
            first_try <= 1'b1;
         end else begin
            if (load_cw)
               first_try <= 1'b0;
            if (chk_req && det_err)
               retry_q <= retry_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/fsec_encoder.sv
`timescale 1ns/1ps
module fsec_encoder
   import fsec_pkg::*;
#(
   parameter int DATA_W    = 7,
   parameter int PAR_W     = 8,
   parameter int MAX_RETRY = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [DATA_W-1:0]       in_data,
   input  logic                    inj_en,
   input  logic [PAR_W-1:0]        inj_mask,
   output logic [DATA_W+PAR_W-1:0] cw_out,
   output logic                    chk_req,
   input  logic                    det_err,
   output logic                    wr_en,
   output logic                    unrec_err
);
   localparam int CW_W = DATA_W + PAR_W;

   if (DATA_W != CODE_K || PAR_W != CODE_R) begin : g_bad_code
      $error("fsec_encoder: only the (15,7) code is supported");
   end
   if (MAX_RETRY < 1) begin : g_bad_retry
      $error("fsec_encoder: MAX_RETRY must be at least 1");
   end

   logic              accept, load_cw, first_try;
   logic [DATA_W-1:0] data_q;
   logic [PAR_W-1:0]  mask_q;
   logic [CW_W-1:0]   cw_q;

   fsec_retry_fsm #(.MAX_RETRY(MAX_RETRY)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .det_err   (det_err),
      .in_ready  (in_ready),
      .accept    (accept),
      .load_cw   (load_cw),
      .first_try (first_try),
      .chk_req   (chk_req),
      .wr_en     (wr_en),
      .unrec_err (unrec_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         mask_q <= '0;
      end else if (accept) begin
         data_q <= in_data;
         mask_q <= inj_en ? inj_mask : '0;
      end
   end

   // Systematic part: one register per data bit, fed only by that bit
   for (genvar i = 0; i < DATA_W; i++) begin : g_copy
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cw_q[i] <= 1'b0;
         else if (load_cw)
            cw_q[i] <= data_q[i];
      end
   end

   // Parity part: an independent cone per bit
   for (genvar j = 0; j < PAR_W; j++) begin : g_par
      logic flip_j;
      always_comb flip_j = first_try & mask_q[j];
      fsec_par_cone #(
         .W   (DATA_W),
         .TAP (DATA_W'(parity_taps(j)))
      ) u_cone (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (load_cw),
         .din   (data_q),
         .flip  (flip_j),
         .q     (cw_q[DATA_W+j])
      );
   end

   assign cw_out = cw_q;
endmodule

// File: rtl/fsec_encoder_chk.sv
`timescale 1ns/1ps
module fsec_encoder_chk #(
   parameter int DATA_W    = 7,
   parameter int PAR_W     = 8,
   parameter int MAX_RETRY = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    in_ready,
   input logic [DATA_W-1:0]       in_data,
   input logic [DATA_W+PAR_W-1:0] cw_out,
   input logic                    chk_req,
   input logic                    det_err,
   input logic                    wr_en,
   input logic                    unrec_err
);
   localparam int FW = $clog2(MAX_RETRY + 2) + 1;

   logic [DATA_W-1:0] last_data;
   logic [FW-1:0]     fails;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_data <= '0;
         fails     <= '0;
      end else if (in_valid && in_ready) begin
         last_data <= in_data;
         fails     <= '0;
      end else if (chk_req && det_err) begin
         fails <= fails + 1'b1;
      end
   end

   // R1
   sys_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_req |-> cw_out[DATA_W-1:0] == last_data);
   // R4
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !chk_req && !wr_en && !unrec_err);
   // R5
   wr_after_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(chk_req) && !$past(det_err));
   // R5
   wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $stable(cw_out));
   // R6
   retry_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_req && det_err |=> !wr_en && !chk_req);
   // R7
   cap_reached_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unrec_err |-> fails == FW'(MAX_RETRY + 1));
   // R7
   under_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> fails <= FW'(MAX_RETRY));
   // R7
   excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && unrec_err));
endmodule

bind fsec_encoder fsec_encoder_chk #(
   .DATA_W    (DATA_W),
   .PAR_W     (PAR_W),
   .MAX_RETRY (MAX_RETRY)
) u_chk (.*);

// File: tb/fsec_encoder_tb.sv
`timescale 1ns/1ps
module fsec_encoder_tb;
   localparam int MAXR = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [6:0]  in_data = '0;
   logic        inj_en = 1'b0;
   logic [7:0]  inj_mask = '0;
   logic [14:0] cw_out;
   logic        chk_req;
   logic        det_err = 1'b0;
   logic        wr_en;
   logic        unrec_err;

   int n_vec = 0;
   int n_bad = 0;

   fsec_encoder #(.MAX_RETRY(MAXR)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .inj_en(inj_en), .inj_mask(inj_mask),
      .cw_out(cw_out), .chk_req(chk_req), .det_err(det_err),
      .wr_en(wr_en), .unrec_err(unrec_err)
   );

   always #2 clk = ~clk;

   function automatic logic [14:0] ref_cw(input logic [6:0] m);
      logic [7:0] p;
      p[0] = m[0]^m[4]^m[6];
      p[1] = m[0]^m[1]^m[4]^m[5]^m[6];
      p[2] = m[0]^m[1]^m[2]^m[4]^m[5];
      p[3] = m[1]^m[2]^m[3]^m[5]^m[6];
      p[4] = m[0]^m[2]^m[3];
      p[5] = m[1]^m[3]^m[4];
      p[6] = m[2]^m[4]^m[5];
      p[7] = m[3]^m[5]^m[6];
      return {p, m};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Offers one word, plays detector, reports what came out.
   // force_n: number of checks the detector rejects regardless of content.
   task automatic run_word(input logic [6:0] d, input logic inj, input logic [7:0] mask,
                           input int force_n, output int n_chk, output int wr_at,
                           output int drop_at, output logic [14:0] wr_cw,
                           output logic [14:0] first_cw, output int ready_busy);
      n_chk = 0; wr_at = -1; drop_at = -1; wr_cw = '0; first_cw = '0; ready_busy = 0;
      @(negedge clk);
      in_valid = 1'b1; in_data = d; inj_en = inj; inj_mask = mask;
      @(posedge clk);
      for (int k = 1; k < 40; k++) begin
         @(negedge clk);
         in_data = ~d; inj_en = 1'b1; inj_mask = 8'hFF;   // busy: must be ignored
         det_err = 1'b0;
         if (in_ready) ready_busy++;
         if (chk_req) begin
            if (n_chk == 0) first_cw = cw_out;
            det_err = (n_chk < force_n) || (cw_out != ref_cw(cw_out[6:0]));
            n_chk++;
         end
         if (wr_en) begin wr_at = k; wr_cw = cw_out; end
         if (unrec_err) drop_at = k;
         if (wr_en || unrec_err) begin
            in_valid = 1'b0; inj_en = 1'b0; inj_mask = '0;
            break;
         end
      end
      @(negedge clk);
      det_err = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int nc, wa, da, rb;
      logic [14:0] wc, fc;
      #9;
      // R3 reset state
      check("R3 in_ready", 32'(in_ready), 1);
      check("R3 outputs", {29'd0, chk_req, wr_en, unrec_err}, 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);

      // R2 known example, m1 only
      run_word(7'h02, 1'b0, 8'h00, 0, nc, wa, da, wc, fc, rb);
      check("R2 m1-only codeword", 32'(wc), 32'h1702);

      // R1 R2 R4 R5 exhaustive sweep
      for (int d = 0; d < 128; d++) begin
         run_word(7'(d), 1'b0, 8'h00, 0, nc, wa, da, wc, fc, rb);
         check("R1 R2 written codeword", 32'(wc), 32'(ref_cw(7'(d))));
         if (d % 16 == 0) begin
            check("R5 single check", 32'(nc), 1);
            check("R5 write latency", 32'(wa), 3);
            check("R4 ready low while busy", 32'(rb), 0);
            check("R7 no drop on clean word", 32'(da), 32'hFFFFFFFF);
         end
      end

      // R8 R9 single-bit injection per parity bit
      for (int j = 0; j < 8; j++) begin
         run_word(7'h55, 1'b1, 8'(1 << j), 0, nc, wa, da, wc, fc, rb);
         check("R9 one bit flipped", 32'(fc ^ ref_cw(7'h55)), 32'(1 << (7 + j)));
         check("R8 retry cleans word", 32'(wc), 32'(ref_cw(7'h55)));
         check("R6 re-check spacing", 32'(wa), 5);
         check("R8 two checks", 32'(nc), 2);
      end

      // R8 full mask, data bits untouched
      run_word(7'h3C, 1'b1, 8'hFF, 0, nc, wa, da, wc, fc, rb);
      check("R8 data bits intact", 32'(fc[6:0]), 32'h3C);
      check("R8 parity inverted", 32'(fc[14:7]), 32'(~ref_cw(7'h3C) >> 7) & 32'hFF);

      // R6 R7 just under the cap: MAXR rejects, then written
      run_word(7'h6B, 1'b0, 8'h00, MAXR, nc, wa, da, wc, fc, rb);
      check("R7 written at cap-1", 32'(wc), 32'(ref_cw(7'h6B)));
      check("R6 write after retries", 32'(wa), 3 + 2 * MAXR);
      check("R7 no drop", 32'(da), 32'hFFFFFFFF);

      // R7 over the cap: dropped
      run_word(7'h11, 1'b0, 8'h00, 100, nc, wa, da, wc, fc, rb);
      check("R7 check count", 32'(nc), MAXR + 1);
      check("R7 drop pulse time", 32'(da), 3 + 2 * MAXR);
      check("R7 no write", 32'(wa), 32'hFFFFFFFF);
      check("R7 ready after drop", 32'(in_ready), 1);

      // R4 the block recovers and the next word is intact
      run_word(7'h7F, 1'b0, 8'h00, 0, nc, wa, da, wc, fc, rb);
      check("R4 next word intact", 32'(wc), 32'(ref_cw(7'h7F)));

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule